// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is a single-byte SPI master behind a small word-wide register bus. Software first sets the serial clock divider, the clock polarity and phase, the bit order for each direction and the MISO sampling delay. It then picks one of two slave selects and asserts it. Each write to the transmit register sends one byte on MOSI and collects one byte from MISO at the same time. The received byte goes to a receive register. A sticky ready flag is set in a cause register, and a mask register decides whether that flag drives the interrupt line.

The select line is controlled only by software, so one select can stay asserted across any number of bytes. All settings are copied when a transfer starts. Changing them during a byte therefore has no effect on that byte.

Top module: `spi_byte_master`

## Requirements
- R1: After synchronous reset both selects are high (`spi_cs_n` = 2'b11), SCK is 0, `irq` is 0, and every readable register reads 0.
- R2: A write to the transmit register (word address 2) starts one 8-bit transfer using only `bus_wdata[7:0]`. Bit 8 of the control register (word address 0) reads 1 while the transfer is running.
- R3: When a transfer ends, the received byte can be read at bits [7:0] of word address 3 and bit 0 of the cause register (word address 4) is 1. That bit stays 1 until software clears it.
- R4: Writing the cause register with bit 0 = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R5: `irq` is 1 only when the cause flag is 1 and bit 0 of the mask register (word address 5) is 1.
- R6: Control bit 0 asserts the select and control bit 1 chooses the line: 0 drives `spi_cs_n[0]` low, 1 drives `spi_cs_n[1]` low. The select stays low between bytes until software clears control bit 0.
- R7: In the configuration register (word address 1), bit 8 sets the SCK idle level and bit 9 sets the phase. With bit 9 = 0 data is sampled on the leading edge; with bit 9 = 1 it is sampled on the trailing edge. All four combinations exchange bytes correctly.
- R8: Configuration bit 10 makes the transmit side send bit 0 first, and bit 11 makes the receive side store the first bit into bit 0. When a bit is 0, that side is MSB-first. The two bits act independently.
- R9: Each SCK half period lasts 2 × N core clocks, where N is configuration bits [3:0]. N = 0 is treated as N = 1. Bit 4 of the divider field does not change the rate.
- R10: The timing register (word address 6, bits [1:0]) sets the MISO sample point. Values 0 and 1 sample on the SCK edge. Values 2 and 3 sample one core clock later. Every setting returns correct data.
- R11: A write to the transmit register while a transfer is running is ignored and does not change the byte being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 2 | Active-low slave selects |
| irq | output | 1 | Masked completion interrupt |

## Verification
A slave model in the bench follows the programmed polarity, phase and bit orders, and it checks both directions in every mode. A phase error would corrupt the byte seen on one side. Swapped or tied bit-order enables would return a bit-reversed byte in the mixed-order case. The bench measures the SCK half period at the smallest divider, at N = 0 and at the largest divider, so an off-by-one or an unguarded zero would give a wrong count or a stuck clock. It also checks that the cause flag ignores a write of 1, that a transmit write during a busy transfer leaves the outgoing byte unchanged, and that the select stays low between two consecutive bytes.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int unsigned BUS_W    = 32;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned IDX_W    = $clog2(BYTE_W);
    localparam int unsigned EDGES    = 2 * BYTE_W;
    localparam int unsigned ECNT_W   = $clog2(EDGES) + 1;
    localparam int unsigned DIV_W    = 5;
    localparam int unsigned NIB_W    = 4;
    localparam int unsigned HALF_W   = NIB_W + 2;
    localparam int unsigned NUM_SEL  = 2;
    localparam int unsigned DLY_W    = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG   = 3'd1;
    localparam logic [ADDR_W-1:0] A_TXD   = 3'd2;
    localparam logic [ADDR_W-1:0] A_RXD   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAUSE = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;
    localparam logic [ADDR_W-1:0] A_TIME  = 3'd6;

    typedef struct packed {
        logic             rx_lsb;
        logic             tx_lsb;
        logic             cpha;
        logic             cpol;
        logic [DIV_W-1:0] div;
    } spi_cfg_t;

    // half period in core clocks: 2*N, with N=0 promoted to 1
    function automatic logic [HALF_W-1:0] half_cycles(input logic [NIB_W-1:0] nib);
        logic [NIB_W-1:0] n;
        n = (nib == '0) ? NIB_W'(1) : nib;
        return {1'b0, n, 1'b0};
    endfunction

    function automatic logic [IDX_W-1:0] bit_pos(input logic lsb_first,
                                                 input logic [IDX_W-1:0] idx);
        return lsb_first ? idx : IDX_W'(BYTE_W - 1) - idx;
    endfunction

endpackage

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
    import spi_byte_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BUS_W-1:0]       wdata,
    output logic [BUS_W-1:0]       rdata,
    input  logic                   busy,
    input  logic                   done,
    input  logic [BYTE_W-1:0]      rx_byte,
    output spi_cfg_t               cfg,
    output logic [DLY_W-1:0]       dly,
    output logic                   cs_active,
    output logic                   cs_idx,
    output logic                   cause,
    output logic                   mask,
    output logic                   start,
    output logic [BYTE_W-1:0]      tx_byte
);

    logic [BYTE_W-1:0] rxd_q;

    assign start   = we && (addr == A_TXD) && !busy;
    assign tx_byte = wdata[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            dly       <= '0;
            cs_active <= 1'b0;
            cs_idx    <= 1'b0;
            mask      <= 1'b0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    cs_active <= wdata[0];
                    cs_idx    <= wdata[1];
                end
                A_CFG:  cfg  <= '{rx_lsb: wdata[11], tx_lsb: wdata[10], cpha: wdata[9],
                                  cpol: wdata[8], div: wdata[DIV_W-1:0]};
                A_TIME: dly  <= wdata[DLY_W-1:0];
                A_MASK: mask <= wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= 1'b0;
            rxd_q <= '0;
        end else if (done) begin
            cause <= 1'b1;
            rxd_q <= rx_byte;
        end else if (we && (addr == A_CAUSE) && !wdata[0]) begin
            cause <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = {{(BUS_W-9){1'b0}}, busy, 6'd0, cs_idx, cs_active};
            A_CFG:   rdata = {{(BUS_W-12){1'b0}}, cfg.rx_lsb, cfg.tx_lsb, cfg.cpha,
                              cfg.cpol, {(8-DIV_W){1'b0}}, cfg.div};
            A_RXD:   rdata = {{(BUS_W-BYTE_W){1'b0}}, rxd_q};
            A_CAUSE: rdata = {{(BUS_W-1){1'b0}}, cause};
            A_MASK:  rdata = {{(BUS_W-1){1'b0}}, mask};
            A_TIME:  rdata = {{(BUS_W-DLY_W){1'b0}}, dly};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_sck_div.sv
module spi_sck_div
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);

    logic [HALF_W-1:0] cnt;

    assign tick = run && (cnt == half - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + HALF_W'(1);
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_in,
    input  spi_cfg_t          cfg_live,
    input  logic [DLY_W-1:0]  dly_live,
    input  logic              tick,
    input  logic              miso,
    output logic              run,
    output logic [HALF_W-1:0] half,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sck,
    output logic              mosi
);

    spi_cfg_t          snap;
    logic              late;
    logic [BYTE_W-1:0] txb;
    logic [BYTE_W-1:0] rxb;
    logic [ECNT_W-1:0] ecnt;
    logic [IDX_W-1:0]  tx_idx;
    logic [IDX_W-1:0]  rx_idx;
    logic              sck_int;
    logic              pend;
    logic              sample_edge;
    logic              shift_ok;
    logic              first_edge;
    logic              last_edge;

    assign half        = half_cycles(snap.div[NIB_W-1:0]);
    assign run         = busy && (ecnt < ECNT_W'(EDGES));
    assign done        = busy && (ecnt == ECNT_W'(EDGES)) && !pend;
    assign rx_byte     = rxb;
    assign first_edge  = (ecnt == '0);
    assign last_edge   = (ecnt == ECNT_W'(EDGES - 1));
    // edge number ecnt+1 is odd (leading) when ecnt is even
    assign sample_edge = (~ecnt[0]) ^ snap.cpha;
    assign shift_ok    = !sample_edge && !(snap.cpha ? first_edge : last_edge);
    assign sck         = (busy ? snap.cpol : cfg_live.cpol) ^ sck_int;
    assign mosi        = busy ? txb[bit_pos(snap.tx_lsb, tx_idx)] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            snap    <= '0;
            late    <= 1'b0;
            txb     <= '0;
            rxb     <= '0;
            ecnt    <= '0;
            tx_idx  <= '0;
            rx_idx  <= '0;
            sck_int <= 1'b0;
            pend    <= 1'b0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            snap    <= cfg_live;
            late    <= dly_live[1];
            txb     <= tx_in;
            rxb     <= '0;
            ecnt    <= '0;
            tx_idx  <= '0;
            rx_idx  <= '0;
            sck_int <= 1'b0;
            pend    <= 1'b0;
        end else if (busy) begin
            if (pend) begin
                rxb[bit_pos(snap.rx_lsb, rx_idx)] <= miso;
                rx_idx <= rx_idx + IDX_W'(1);
                pend   <= 1'b0;
            end
            if (tick) begin
                sck_int <= ~sck_int;
                ecnt    <= ecnt + ECNT_W'(1);
                if (sample_edge) begin
                    if (late) begin
                        pend <= 1'b1;
                    end else begin
                        rxb[bit_pos(snap.rx_lsb, rx_idx)] <= miso;
                        rx_idx <= rx_idx + IDX_W'(1);
                    end
                end else if (shift_ok) begin
                    tx_idx <= tx_idx + IDX_W'(1);
                end
            end
            if (done) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [1:0]        spi_cs_n,
    output logic              irq
);

    spi_cfg_t          cfg;
    logic [DLY_W-1:0]  dly;
    logic              cs_active;
    logic              cs_idx;
    logic              cause;
    logic              mask;
    logic              start;
    logic [BYTE_W-1:0] tx_byte;
    logic              busy;
    logic              done;
    logic [BYTE_W-1:0] rx_byte;
    logic              run;
    logic              tick;
    logic [HALF_W-1:0] half;

    spi_byte_regs i_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .busy(busy), .done(done), .rx_byte(rx_byte),
        .cfg(cfg), .dly(dly), .cs_active(cs_active), .cs_idx(cs_idx),
        .cause(cause), .mask(mask), .start(start), .tx_byte(tx_byte)
    );

    spi_sck_div i_div (
        .clk(clk), .rst(rst), .run(run), .half(half), .tick(tick)
    );

    spi_shift_engine i_eng (
        .clk(clk), .rst(rst), .start(start), .tx_in(tx_byte), .cfg_live(cfg),
        .dly_live(dly), .tick(tick), .miso(spi_miso), .run(run), .half(half),
        .busy(busy), .done(done), .rx_byte(rx_byte), .sck(spi_sck), .mosi(spi_mosi)
    );

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign spi_cs_n[g] = !(cs_active && (cs_idx == g[0]));
    end

    assign irq = cause & mask;

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
    import spi_byte_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              spi_sck,
    input logic [1:0]        spi_cs_n,
    input logic              irq,
    input logic              busy,
    input logic              cause,
    input logic              mask,
    input logic              cs_active,
    input spi_cfg_t          cfg
);

    a_r6_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~spi_cs_n) <= 1);

    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        !cs_active |-> (spi_cs_n == 2'b11));

    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        (cause && !(bus_we && bus_addr == A_CAUSE)) |=> cause);

    a_r3_done_flags: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> cause);

    a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_we && bus_addr == A_TXD) |=> busy);

    a_r9_min_half: assert property (@(posedge clk) disable iff (rst)
        (busy && !$stable(spi_sck)) |=> $stable(spi_sck));

    a_r5_masked_off: assert property (@(posedge clk) disable iff (rst)
        !mask |-> !irq);

    a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_sck == cfg.cpol));

endmodule

bind spi_byte_master spi_byte_master_chk i_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .irq(irq), .busy(busy),
    .cause(cause), .mask(mask), .cs_active(cs_active), .cfg(cfg)
);

// File: tb/test_spi_byte_master.sv
`timescale 1ns/100ps
module test_spi_byte_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [1:0]  spi_cs_n;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    spi_byte_master i_spi_byte_master (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model
    logic       s_cpol = 0, s_cpha = 0, s_mlsb_tx = 0, s_mlsb_rx = 0;
    logic [7:0] s_out = '0, s_in = '0;
    int         s_cnt = 0, s_rcnt = 0;
    int         last_t = -1, hmin = 0, hmax = 0;
    int         cs_rises = 0;

    function automatic int pos(input logic lsb, input int i);
        return lsb ? i : 7 - i;
    endfunction

    initial spi_miso = 1'b0;

    always @(spi_sck) begin
        if (spi_cs_n != 2'b11) begin
            logic leading;
            leading = (spi_sck != s_cpol);
            if (leading ^ s_cpha) begin
                if (s_rcnt < 8) s_in[pos(s_mlsb_tx, s_rcnt)] = spi_mosi;
                s_rcnt++;
            end else if (!s_cpha) begin
                s_cnt++;
                if (s_cnt < 8) spi_miso = s_out[pos(s_mlsb_rx, s_cnt)];
            end else begin
                if (s_cnt < 8) spi_miso = s_out[pos(s_mlsb_rx, s_cnt)];
                s_cnt++;
            end
            if (last_t >= 0) begin
                if (hmin == 0 || cyc - last_t < hmin) hmin = cyc - last_t;
                if (cyc - last_t > hmax) hmax = cyc - last_t;
            end
            last_t = cyc;
        end
    end

    always @(posedge spi_cs_n[1]) cs_rises++;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic prep_slave(input logic [7:0] sb);
        s_out = sb; s_in = '0; s_cnt = 0; s_rcnt = 0;
        spi_miso = sb[pos(s_mlsb_rx, 0)];
        last_t = -1; hmin = 0; hmax = 0;
    endtask

    task automatic wait_ready(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd4, v);
            if (v[0]) begin ok = 1; break; end
        end
    endtask

    // one vector: cpol cpha txlsb rxlsb nib[3:0] dly[1:0] tx[7:0] slave[7:0]
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 2'd1, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 2'd1, 8'h81, 8'h7E},
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 2'd0, 8'h12, 8'hF0},
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 2'd1, 8'hC3, 8'h5A},
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd2, 2'd1, 8'h01, 8'h80},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 2'd1, 8'h0F, 8'h0F},
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 2'd2, 8'h96, 8'hE1},
        {1'b0, 1'b0, 1'b0, 1'b1, 4'd15, 2'd3, 8'h6D, 8'h2B}
    };

    initial begin
        logic [31:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check(spi_cs_n == 2'b11, "R1 selects idle", {30'd0, spi_cs_n}, 32'd3);
        check(spi_sck == 1'b0 && irq == 1'b0, "R1 sck/irq low", {30'd0, spi_sck, irq}, 32'd0);
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], v);
            check(v == 32'd0, "R1 register reset", v, 32'd0);
        end

        // vector table: R2 R7 R8 R9 R10
        for (int k = 0; k < NV; k++) begin
            logic [25:0] e;
            int exp_half;
            e = VEC[k];
            s_cpol = e[25]; s_cpha = e[24]; s_mlsb_tx = e[23]; s_mlsb_rx = e[22];
            exp_half = (e[21:18] == 0) ? 2 : 2 * int'(e[21:18]);
            wr(3'd1, {20'd0, e[22], e[23], e[24], e[25], 3'd0, 1'b1, e[21:18]});
            wr(3'd6, {30'd0, e[17:16]});
            #1;
            check(spi_sck == e[25], "R7 idle level", {31'd0, spi_sck}, {31'd0, e[25]});
            wr(3'd0, 32'h1);
            prep_slave(e[7:0]);
            wr(3'd2, {24'hFFFFFF, e[15:8]});
            wait_ready(ok);
            check(ok, "R3 ready flag set", {31'd0, ok}, 32'd1);
            rd(3'd3, v);
            check(v == {24'd0, e[7:0]}, "R7/R8/R10 received byte", v, {24'd0, e[7:0]});
            check(s_in == e[15:8], "R2/R8 byte seen by slave", {24'd0, s_in}, {24'd0, e[15:8]});
            check(hmin == exp_half && hmax == exp_half, "R9 half period",
                  hmin, exp_half);
            wr(3'd4, 32'h0);
            wr(3'd0, 32'h0);
        end

        // R3 sticky, R4 clear semantics, R5 mask
        s_cpol = 0; s_cpha = 0; s_mlsb_tx = 0; s_mlsb_rx = 0;
        wr(3'd1, 32'h0000_0011);
        wr(3'd6, 32'h1);
        wr(3'd0, 32'h1);
        prep_slave(8'h44);
        wr(3'd2, 32'h0000_0022);
        wait_ready(ok);
        repeat (40) @(negedge clk);
        rd(3'd4, v);
        check(v[0] == 1'b1, "R3 flag sticky", v, 32'd1);
        #1 check(irq == 1'b0, "R5 irq masked off", {31'd0, irq}, 32'd0);
        wr(3'd5, 32'h1);
        #1 check(irq == 1'b1, "R5 irq unmasked", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h1);
        rd(3'd4, v);
        check(v[0] == 1'b1, "R4 write one no effect", v, 32'd1);
        wr(3'd4, 32'h0);
        rd(3'd4, v);
        check(v[0] == 1'b0, "R4 write zero clears", v, 32'd0);
        #1 check(irq == 1'b0, "R5 irq follows clear", {31'd0, irq}, 32'd0);

        // R11 busy bit and ignored write
        prep_slave(8'h99);
        wr(3'd2, 32'h0000_00B7);
        rd(3'd0, v);
        check(v[8] == 1'b1, "R2 busy bit", v, 32'h101);
        wr(3'd2, 32'h0000_0000);
        wait_ready(ok);
        check(s_in == 8'hB7, "R11 busy write ignored", {24'd0, s_in}, 32'hB7);
        rd(3'd3, v);
        check(v == 32'h99, "R11 receive unaffected", v, 32'h99);
        wr(3'd4, 32'h0);

        // R6 select index 1 held across two bytes
        wr(3'd0, 32'h0);
        #1 check(spi_cs_n == 2'b11, "R6 select released", {30'd0, spi_cs_n}, 32'd3);
        wr(3'd0, 32'h3);
        #1 check(spi_cs_n == 2'b01, "R6 index one", {30'd0, spi_cs_n}, 32'd1);
        cs_rises = 0;
        prep_slave(8'h11);
        wr(3'd2, 32'h55);
        wait_ready(ok);
        wr(3'd4, 32'h0);
        prep_slave(8'h22);
        wr(3'd2, 32'hAA);
        wait_ready(ok);
        check(s_in == 8'hAA, "R6 second byte", {24'd0, s_in}, 32'hAA);
        check(cs_rises == 0 && spi_cs_n == 2'b01, "R6 select spans bytes",
              cs_rises, 32'd0);
        wr(3'd0, 32'h2);
        #1 check(spi_cs_n == 2'b11, "R6 index kept, inactive", {30'd0, spi_cs_n}, 32'd3);

        finish_run();
    end

endmodule